// File: doc/BRIEF.md
# Nibble-RAM Cartridge Bank Controller

This block sits between a CPU address/data bus and an external program ROM. It holds a small banking state and a built-in 512-entry RAM that is 4 bits wide. The lower 16 KiB of CPU address space always shows the first ROM bank. The next 16 KiB shows one selectable bank. A 512-byte window at 0xA000 reaches the internal RAM.

Control writes land in the lower half of the 32 KiB ROM space. Address bit 8, together with the address range, decides which register a write reaches. A RAM write stores only the low nibble. A RAM read returns that nibble with the upper four bits forced to ones. While the RAM is switched off, the window reads as 0xFF and ignores writes.

The ROM array is outside the block. The block produces the ROM byte address and passes the ROM data through to the CPU. Reads are combinational. Register and RAM updates take effect on the rising clock edge that samples `cpu_wr`.

Top module: `nibram_bank_ctrl`

## Requirements
- R1: After reset the selected bank is 1 and the RAM is off. A read of 0x4000 drives `rom_addr` = 0x04000, and a read of 0xA000 returns 0xFF.
- R2: For a read in 0x0000–0x3FFF, `rom_addr` equals the CPU address, with bank bits zero. `cpu_rdata` equals `rom_rdata`.
- R3: For a read in 0x4000–0x7FFF, `rom_addr` = bank × 0x4000 + (address − 0x4000), that is {bank, address[13:0]}. `cpu_rdata` equals `rom_rdata`.
- R4: A write in 0x0000–0x1FFF with address bit 8 = 0 switches the RAM on when the data is 0x0A. Any other data value switches it off.
- R5: A write in 0x0000–0x1FFF with address bit 8 = 1 leaves the RAM on/off state unchanged.
- R6: A write in 0x2000–0x3FFF with address bit 8 = 1 loads the bank from data bits [3:0]. A nibble of 0 selects bank 1.
- R7: A write in 0x2000–0x3FFF with address bit 8 = 0 leaves the bank unchanged.
- R8: While the RAM is on, a write in 0xA000–0xA1FF stores data[3:0] at entry address[8:0]. A read there returns {4'hF, stored nibble}, and each of the 512 entries is distinct.
- R9: While the RAM is off, reads in 0xA000–0xA1FF return 0xFF, and writes there do not change the stored contents.
- R10: Reads outside 0x0000–0x7FFF and 0xA000–0xA1FF return 0xFF. This includes 0xA200 and higher, so those addresses do not alias the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled on the clock edge |
| rom_rdata | input | 8 | Byte returned by the external ROM at `rom_addr` |
| rom_addr | output | 18 | Byte address into the external ROM |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
The bench targets address bit 8 in both control ranges. A decoder that ignored this bit would let a bank write at 0x2000 change the bank, or let an enable write at 0x0100 turn the RAM on. Bank writes of 0x00 and 0x10 are checked. A design that lacked the zero-to-one remap would then map the upper window onto bank 0. The bench also reads 0xA200 and stores to 0xA1FF and 0xA005. A design that decoded too few address bits would alias the RAM or return a full byte. A further store is made while the RAM is off and is then read back after the RAM is switched on. A design that did not gate writes by the enable would have overwritten the stored nibble.

// File: rtl/nibram_bank_ctrl.sv
`timescale 1ns/1ps
module nibram_bank_ctrl #(
  parameter int BANK_W   = 4,
  parameter int RAM_AW   = 9,
  parameter logic [7:0] ON_KEY = 8'h0A
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             cpu_addr,
  input  logic [7:0]              cpu_wdata,
  input  logic                    cpu_wr,
  input  logic [7:0]              rom_rdata,
  output logic [BANK_W+13:0]      rom_addr,
  output logic [7:0]              cpu_rdata
);
  localparam int DEPTH = 1 << RAM_AW;
  localparam int WIN_W = 16 - RAM_AW;
  localparam logic [WIN_W-1:0] WIN_TAG = WIN_W'(16'hA000 >> RAM_AW);

  logic [BANK_W-1:0] bank_q;
  logic              ram_on;
  logic [3:0]        mem [DEPTH];

  wire in_fixed  = cpu_addr[15:14] == 2'b00;
  wire in_switch = cpu_addr[15:14] == 2'b01;
  wire in_ram    = cpu_addr[15:RAM_AW] == WIN_TAG;
  wire en_wr     = cpu_wr && cpu_addr[15:13] == 3'b000 && !cpu_addr[8];
  wire bank_wr   = cpu_wr && cpu_addr[15:13] == 3'b001 &&  cpu_addr[8];
  wire [BANK_W-1:0] new_bank = cpu_wdata[BANK_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= BANK_W'(1);
      ram_on <= 1'b0;
    end else begin
      if (en_wr)   ram_on <= (cpu_wdata == ON_KEY);
      if (bank_wr) bank_q <= (new_bank == '0) ? BANK_W'(1) : new_bank;
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_wr && in_ram && ram_on) mem[cpu_addr[RAM_AW-1:0]] <= cpu_wdata[3:0];
  end

  assign rom_addr = {in_switch ? bank_q : {BANK_W{1'b0}}, cpu_addr[13:0]};

  always_comb begin
    if (in_fixed || in_switch)  cpu_rdata = rom_rdata;
    else if (in_ram && ram_on)  cpu_rdata = {4'hF, mem[cpu_addr[RAM_AW-1:0]]};
    else                        cpu_rdata = 8'hFF;
  end

  // R6
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && new_bank != '0) |=> bank_q == $past(new_bank));
  // R6
  bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_wr && new_bank == '0) |=> bank_q == BANK_W'(1));
  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr |=> $stable(bank_q));
  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(ram_on));
  // R9
  ram_off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ram && !ram_on) |-> cpu_rdata == 8'hFF);
  // R8
  ram_high_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ram |-> cpu_rdata[7:4] == 4'hF);
  // R3
  switch_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_switch |-> (rom_addr[BANK_W+13:14] == bank_q && cpu_rdata == rom_rdata));
endmodule

// File: tb/tb_nibram_bank_ctrl.sv
`timescale 1ns/1ps
module tb_nibram_bank_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic        cpu_wr = 0;
  logic [7:0]  rom_rdata;
  logic [17:0] rom_addr;
  logic [7:0]  cpu_rdata;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [7:0]  data;
    logic [17:0] ra;
    bit          chk_ra;
    string       tag;
  } item_t;
  item_t expq[$];

  always #5 clk = ~clk;

  function automatic logic [7:0] rom_fn(input logic [17:0] a);
    return a[7:0] ^ {a[17:14], a[11:8]};
  endfunction
  assign rom_rdata = rom_fn(rom_addr);

  nibram_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .rom_rdata(rom_rdata), .rom_addr(rom_addr), .cpu_rdata(cpu_rdata)
  );

  always @(negedge clk) begin
    if (expq.size() > 0) begin
      item_t it;
      it = expq.pop_front();
      total++;
      if (cpu_rdata !== it.data) begin
        bad++;
        $display("FAIL %s: rdata actual=%02h expected=%02h", it.tag, cpu_rdata, it.data);
      end
      if (it.chk_ra) begin
        total++;
        if (rom_addr !== it.ra) begin
          bad++;
          $display("FAIL %s: rom_addr actual=%05h expected=%05h", it.tag, rom_addr, it.ra);
        end
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(posedge clk); #1;
    cpu_wr = 0;
  endtask

  task automatic rd_rom(input logic [15:0] a, input logic [17:0] ra, input string tag);
    item_t it;
    @(posedge clk); #1;
    cpu_addr = a;
    it.data = rom_fn(ra); it.ra = ra; it.chk_ra = 1; it.tag = tag;
    expq.push_back(it);
  endtask

  task automatic rd_dat(input logic [15:0] a, input logic [7:0] d, input string tag);
    item_t it;
    @(posedge clk); #1;
    cpu_addr = a;
    it.data = d; it.ra = '0; it.chk_ra = 0; it.tag = tag;
    expq.push_back(it);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd_rom(16'h4000, 18'h04000, "R1 bank after reset");
    rd_dat(16'hA000, 8'hFF, "R1 ram off after reset");
    rd_rom(16'h0000, 18'h00000, "R2 fixed low");
    rd_rom(16'h3FFF, 18'h03FFF, "R2 fixed high");
    wr(16'h2100, 8'h05);
    rd_rom(16'h4123, 18'h14123, "R3 bank5");
    wr(16'h3FFF, 8'hAF);
    rd_rom(16'h7FFF, 18'h3FFFF, "R3 bank15 top");
    rd_rom(16'h1234, 18'h01234, "R2 fixed ignores bank");
    wr(16'h2000, 8'h07);
    rd_rom(16'h4000, 18'h3C000, "R7 bit8 low ignored");
    wr(16'h2100, 8'h00);
    rd_rom(16'h4000, 18'h04000, "R6 zero to one");
    wr(16'h2100, 8'h03);
    wr(16'h3100, 8'h10);
    rd_rom(16'h4001, 18'h04001, "R6 nibble zero to one");
    wr(16'h0100, 8'h0A);
    rd_dat(16'hA005, 8'hFF, "R5 bit8 high no enable");
    wr(16'h0000, 8'h0A);
    wr(16'hA005, 8'h55);
    wr(16'hA1FF, 8'hA3);
    wr(16'hA105, 8'h09);
    rd_dat(16'hA005, 8'hF5, "R8 nibble read");
    rd_dat(16'hA1FF, 8'hF3, "R8 top entry");
    rd_dat(16'hA105, 8'hF9, "R8 distinct entry");
    rd_dat(16'hA200, 8'hFF, "R10 past window");
    rd_dat(16'h8000, 8'hFF, "R10 unmapped");
    wr(16'h1100, 8'h00);
    rd_dat(16'hA005, 8'hF5, "R5 bit8 high no disable");
    wr(16'h1E00, 8'h00);
    rd_dat(16'hA005, 8'hFF, "R4 disable");
    wr(16'hA005, 8'h77);
    wr(16'h0000, 8'h0A);
    rd_dat(16'hA005, 8'hF5, "R9 write while off ignored");
    wr(16'h0000, 8'h0B);
    rd_dat(16'hA1FF, 8'hFF, "R4 other value disables");
    @(posedge clk); @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule